// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit-level timing that a CAN protocol engine needs. A prescaler divides the clock into time quanta. Each nominal bit is then built from a one-quantum synchronisation segment, a first phase segment and a second phase segment. The phase segment lengths and the prescaler come from programmed fields, and each field is used as its programmed value plus one. The prescaler field is additionally doubled, so one quantum lasts 2*(prescaler+1) clock cycles.

The unit marks the start of every bit with a one-clock transmit-point strobe. At the boundary between the two phase segments it samples the receive line, raises a one-clock sample strobe and holds the sampled value. A falling edge on the receive line while the bus is idle restarts the bit from its synchronisation segment. When the bus is busy, a falling edge moves the sample point to track the remote transmitter. The correction is limited by the programmed jump width and happens at most once per bit. Frame decoding, CRC, stuffing and filtering belong to the blocks that consume these strobes.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2*(brp_i+1) clock cycles. An uncorrected bit lasts (1 + (tseg1_i+1) + (tseg2_i+1)) quanta between successive txpt_o pulses.
- R2: Without correction, sample_o rises (2 + tseg1_i) quanta after the first clock of the bit's synchronisation segment. It is never high in the same cycle as txpt_o.
- R3: txpt_o is high for exactly one clock: the first clock of each synchronisation segment.
- R4: sample_o is a one-clock pulse. bit_o takes the value rx_i had at the sampling clock edge and holds it until the next sample pulse.
- R5: A falling edge of rx_i (rx_i was 1 on the previous edge and is 0 now) while bus_idle_i is 1 restarts the bit. txpt_o is high in the following cycle, and any pending sample of the interrupted bit is dropped.
- R6: With bus_idle_i low, a falling edge in quantum k of the first phase segment (k = 1 for its first quantum) lengthens that segment by min(k, sjw_i+1) quanta.
- R7: With bus_idle_i low, a falling edge in the second phase segment with e quanta left to its nominal end is handled as follows. If e <= sjw_i+1, a new bit starts in the next cycle. Otherwise the segment is shortened by sjw_i+1 quanta.
- R8: After one correction under R6 or R7, further falling edges before the next synchronisation segment have no effect on timing.
- R9: Falling edges inside the synchronisation segment while the bus is busy, and all rising edges, leave the bit timing unchanged.
- R10: While rst_n is low, sample_o and txpt_o are 0 and bit_o is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, already synchronised to clk (1 = recessive) |
| bus_idle_i | input | 1 | High while the protocol engine considers the bus idle |
| brp_i | input | 6 | Prescaler field; quantum = 2*(brp_i+1) cycles |
| tseg1_i | input | 4 | First phase segment field; length tseg1_i+1 quanta |
| tseg2_i | input | 3 | Second phase segment field; length tseg2_i+1 quanta |
| sjw_i | input | 2 | Jump width field; limit sjw_i+1 quanta |
| sample_o | output | 1 | One-clock strobe at the sample point |
| bit_o | output | 1 | Value of rx_i at the latest sample point |
| txpt_o | output | 1 | One-clock strobe at the start of each bit |

## Verification
The properties assume that the timing fields stay constant between one hard synchronisation and the next. They also assume that rx_i is already synchronised, so one rx_i sample per clock is the whole truth about an edge. The stimulus respects both assumptions. Every scenario loads its fields while the line is recessive, then forces a hard synchronisation with the bus marked idle and only afterwards marks the bus busy. Receive edges are driven on the falling clock edge, mid-quantum, so no edge lands on a segment boundary where two rules would compete.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             bit_o,
  output logic             txpt_o
);
  localparam int PC_W  = BRP_W + 1;
  localparam int SJ_W  = SJW_W + 1;
  localparam int TS_MX = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int QC_W  = ((TS_MX > SJ_W) ? TS_MX : SJ_W) + 2;

  typedef enum logic [1:0] {SG_SYNC, SG_PH1, SG_PH2} seg_t;

  seg_t            seg;
  logic [PC_W-1:0] pcnt;
  logic [QC_W-1:0] qcnt;
  logic [SJ_W-1:0] ext, shrt;
  logic            rs_done, rx_prev, smp_q, bit_q;

  wire             tick    = pcnt >= {brp_i, 1'b1};
  wire [SJ_W-1:0]  sjw_eff = SJ_W'(sjw_i) + SJ_W'(1);
  wire             fall    = rx_prev & ~rx_i;
  wire             hard    = fall & bus_idle_i;
  wire             rsync   = fall & ~bus_idle_i & ~rs_done & (seg != SG_SYNC);
  wire [QC_W-1:0]  qinc    = qcnt + QC_W'(1);
  wire [QC_W-1:0]  l2_nom  = QC_W'(tseg2_i) + QC_W'(1);
  wire [QC_W-1:0]  ph2_err = l2_nom - qcnt;
  wire             early   = rsync && (seg == SG_PH2) && (ph2_err <= QC_W'(sjw_eff));
  wire             restart = hard | early;

  wire [SJ_W-1:0]  ext_n   = (rsync && seg == SG_PH1)
                             ? ((qinc <= QC_W'(sjw_eff)) ? SJ_W'(qinc) : sjw_eff)
                             : ext;
  wire [SJ_W-1:0]  shrt_n  = (rsync && seg == SG_PH2 && !early) ? sjw_eff : shrt;
  wire [QC_W-1:0]  l1_last = QC_W'(tseg1_i) + QC_W'(ext_n);
  wire [QC_W-1:0]  l2_last = QC_W'(tseg2_i) - QC_W'(shrt_n);
  wire             ph1_end = tick && (seg == SG_PH1) && (qcnt >= l1_last);
  wire             ph2_end = tick && (seg == SG_PH2) && (qcnt >= l2_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg     <= SG_SYNC;
      pcnt    <= '0;
      qcnt    <= '0;
      ext     <= '0;
      shrt    <= '0;
      rs_done <= 1'b0;
      rx_prev <= 1'b1;
      smp_q   <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      rx_prev <= rx_i;
      smp_q   <= ph1_end && !restart;
      if (ph1_end && !restart) bit_q <= rx_i;
      if (restart) begin
        seg     <= SG_SYNC;
        pcnt    <= '0;
        qcnt    <= '0;
        ext     <= '0;
        shrt    <= '0;
        rs_done <= 1'b0;
      end else begin
        pcnt <= tick ? '0 : pcnt + PC_W'(1);
        ext  <= ext_n;
        shrt <= shrt_n;
        if (rsync) rs_done <= 1'b1;
        if (tick) begin
          case (seg)
            SG_SYNC: begin
              seg  <= SG_PH1;
              qcnt <= '0;
            end
            SG_PH1: begin
              if (ph1_end) begin
                seg  <= SG_PH2;
                qcnt <= '0;
              end else begin
                qcnt <= qinc;
              end
            end
            SG_PH2: begin
              if (ph2_end) begin
                seg     <= SG_SYNC;
                qcnt    <= '0;
                ext     <= '0;
                shrt    <= '0;
                rs_done <= 1'b0;
              end else begin
                qcnt <= qinc;
              end
            end
            default: seg <= SG_SYNC;
          endcase
        end
      end
    end
  end

  assign sample_o = smp_q;
  assign bit_o    = bit_q;
  assign txpt_o   = rst_n && (seg == SG_SYNC) && (pcnt == '0);
endmodule

module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_i,
  input logic bus_idle_i,
  input logic sample_o,
  input logic bit_o,
  input logic txpt_o
);
  a_r3_txpt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    txpt_o |=> !txpt_o);

  a_r4_sample_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |-> $stable(bit_o));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && txpt_o));

  a_r5_hard_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_i) && !rx_i && bus_idle_i) |=> txpt_o);
endmodule

bind can_bit_timer can_bit_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .bus_idle_i(bus_idle_i),
  .sample_o(sample_o), .bit_o(bit_o), .txpt_o(txpt_o)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, rx = 1'b1, idle = 1'b1;
  logic [5:0] brp = 6'd1;
  logic [3:0] ts1 = 4'd5;
  logic [2:0] ts2 = 3'd3;
  logic [1:0] sjw = 2'd1;
  logic       sample, bitv, txpt;
  int n_chk = 0, n_fail = 0;
  int s0, s1, t0, t1, nsmp, bfirst, blast, tx0, tx1;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .bus_idle_i(idle),
    .brp_i(brp), .tseg1_i(ts1), .tseg2_i(ts2), .sjw_i(sjw),
    .sample_o(sample), .bit_o(bitv), .txpt_o(txpt)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int b, input int a, input int c, input int j);
    @(negedge clk);
    brp = 6'(b); ts1 = 4'(a); ts2 = 3'(c); sjw = 2'(j);
  endtask

  task automatic run(input int r1, input int f1, input int r2, input int f2,
                     input bit fidle, input int n);
    @(negedge clk);
    rx = 1'b1; idle = 1'b1;
    repeat (3) @(negedge clk);
    rx = 1'b0;
    s0 = -1; s1 = -1; t0 = -1; t1 = -1; nsmp = 0; bfirst = -1; tx0 = 0; tx1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) tx0 = int'(txpt);
      if (i == 1) tx1 = int'(txpt);
      if (sample) begin
        nsmp++;
        if (s0 < 0) begin s0 = i; bfirst = int'(bitv); end
        else if (s1 < 0) s1 = i;
      end
      if (txpt && i > 0) begin
        if (t0 < 0) t0 = i;
        else if (t1 < 0) t1 = i;
      end
      blast = int'(bitv);
      if (i == 0) idle = 1'b0;
      if (i == r1 || i == r2) rx = 1'b1;
      if (i == f1 || i == f2) begin rx = 1'b0; idle = fidle; end
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R10 sample in reset", int'(sample), 0);
    chk("R10 txpt in reset", int'(txpt), 0);
    chk("R10 bit in reset", int'(bitv), 1);
  endtask

  task automatic test_nominal;
    cfg(1, 5, 3, 1);
    run(-1, -1, -1, -1, 1'b0, 90);
    chk("R3 txpt at sync start", tx0, 1);
    chk("R3 txpt one clock", tx1, 0);
    chk("R2 sample point", s0, 28);
    chk("R1 bit length", t0, 44);
    chk("R1 second bit", t1, 88);
    chk("R2 second sample", s1, 72);
    chk("R4 sample pulses", nsmp, 2);
    chk("R4 sampled dominant", bfirst, 0);
  endtask

  task automatic test_fast;
    cfg(0, 2, 1, 0);
    run(-1, -1, -1, -1, 1'b0, 26);
    chk("R2 fast sample", s0, 8);
    chk("R1 fast bit", t0, 12);
    chk("R1 fast second bit", t1, 24);
  endtask

  task automatic test_slow;
    cfg(3, 1, 0, 0);
    run(-1, -1, -1, -1, 1'b0, 70);
    chk("R2 slow sample", s0, 24);
    chk("R1 slow bit", t0, 32);
    chk("R1 slow second bit", t1, 64);
  endtask

  task automatic test_hard;
    cfg(1, 5, 3, 1);
    run(1, 20, -1, -1, 1'b1, 60);
    chk("R5 restart strobe", t0, 21);
    chk("R5 sample after restart", s0, 49);
    chk("R5 sampled value", bfirst, 0);
  endtask

  task automatic test_ph1;
    cfg(1, 5, 3, 1);
    run(1, 9, -1, -1, 1'b0, 60);
    chk("R6 lengthen 2 sample", s0, 36);
    chk("R6 lengthen 2 bit", t0, 52);
    run(1, 5, -1, -1, 1'b0, 60);
    chk("R6 lengthen 1 sample", s0, 32);
    chk("R6 lengthen 1 bit", t0, 48);
    cfg(1, 5, 3, 0);
    run(1, 13, -1, -1, 1'b0, 60);
    chk("R6 capped sample", s0, 32);
    chk("R6 capped bit", t0, 48);
  endtask

  task automatic test_ph2;
    cfg(1, 5, 3, 1);
    run(1, 29, -1, -1, 1'b0, 40);
    chk("R7 unaffected sample", s0, 28);
    chk("R7 shortened bit", t0, 36);
    run(1, 37, -1, -1, 1'b0, 70);
    chk("R7 early restart", t0, 38);
    chk("R7 sample after restart", s1, 66);
  endtask

  task automatic test_once;
    cfg(1, 5, 3, 1);
    run(1, 5, 20, 38, 1'b0, 60);
    chk("R8 first correction", s0, 32);
    chk("R8 second edge ignored", t0, 48);
    chk("R4 sampled recessive", bfirst, 1);
    chk("R4 single pulse", nsmp, 1);
    chk("R4 value held", blast, 1);
  endtask

  task automatic test_sync_edge;
    cfg(1, 5, 3, 1);
    run(1, 45, -1, -1, 1'b0, 90);
    chk("R9 rising edge ignored", s0, 28);
    chk("R9 bit start", t0, 44);
    chk("R9 sync edge ignored sample", s1, 72);
    chk("R9 sync edge ignored bit", t1, 88);
  endtask

  initial begin
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_nominal();
    test_fast();
    test_slow();
    test_hard();
    test_ph1();
    test_ph2();
    test_once();
    test_sync_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule